// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows the power state of a double-data-rate SDRAM as a memory controller drives it through the clock-enable line. On every rising clock edge it looks at two clock-enable samples, the one taken at the previous edge and the one taken now. It also looks at the decoded command registered now and at an aggregate flag that says whether any bank holds an open row. From these it moves between five states: all banks idle, banks active, precharge power-down, active power-down and self refresh.

Any combination of state, clock-enable pair and command that has no defined meaning raises a one-cycle error pulse, and the state does not move. Leaving self refresh starts a saturating recovery counter. Until that counter reaches its limit, which defaults to 200 cycles so the device clock loop can relock, only Deselect or NOP are accepted and the read-allowed flag stays low. A controller or a verification monitor uses the state and error outputs to catch sequencing faults. Row tracking per bank, refresh scheduling and data timing are handled elsewhere.

Top module: `cke_pstate_top`

## Requirements
- R1: A synchronous active-high reset puts `state` in all-banks-idle, holds `errPulse` low and `readOk` high, and treats the previous clock-enable sample as high. State codes are: idle 0, active 1, precharge power-down 2, active power-down 3, self refresh 4.
- R2: In either power-down state or in self refresh, clock-enable low at both the previous and the current edge keeps the state, whatever the command, with no error.
- R3: In a low-power state, clock-enable low then high with Deselect or NOP leaves it: precharge power-down and self refresh go to idle, and active power-down goes to active.
- R4: In idle or active with `bankActive` low, clock-enable high then low with Deselect or NOP enters precharge power-down.
- R5: In idle or active with `bankActive` low, clock-enable high then low with Auto Refresh enters self refresh.
- R6: In idle or active with `bankActive` high, clock-enable high then low with Deselect or NOP enters active power-down.
- R7: In idle or active, clock-enable high on both edges moves the state to active if `bankActive` is high and to idle if it is low.
- R8: Every other combination is illegal. It includes Auto Refresh with banks active, any other command on a clock-enable edge, and a clock-enable pair that does not fit the state. An illegal combination gives `errPulse` high for the cycle after that edge and leaves the state unchanged. Command codes are: Deselect 0, NOP 1, Activate 2, Read 3, Write 4, Precharge 5, Auto Refresh 6, Mode Set 7.
- R9: After a self-refresh exit, a command other than Deselect or NOP in idle or active is illegal until the recovery count reaches `EXIT_CYCLES`. The count is 0 after the exit edge and rises by one each clock.
- R10: `readOk` is high exactly when the state is idle or active and the recovery count has reached `EXIT_CYCLES`. A Read at the edge where the count is already at its limit is accepted without error. A Read at the edge where the count is one short of the limit is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable level sampled this edge |
| bankActive | input | 1 | High when any bank has an open row |
| cmd | input | 3 | Decoded command code (see R8) |
| state | output | 3 | Current power state (see R1) |
| errPulse | output | 1 | One-cycle flag for an illegal combination |
| readOk | output | 1 | High when a Read would be accepted |

## Verification
Each reachable pair of state and previous clock-enable is driven with both clock-enable levels, all eight commands and both bank-active levels. A design that ignored the previous sample would enter or leave power-down on a steady level. One that did not check the command would leave self refresh on a Read. One that went by the stored state instead of `bankActive` would pick the wrong power-down flavour. The recovery window is tested at its edges: an Activate just after exit, and a Read at the cycle before and at the cycle the count saturates. An off-by-one counter or compare would either accept the early Read or reject the legal one. A long run of mixed traffic against an arithmetic model then covers ordering effects, such as power-down entered inside the recovery window.

// File: rtl/cke_pstate_pkg.sv
package cke_pstate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PPD    = 3'd2,
    ST_APD    = 3'd3,
    ST_SREF   = 3'd4
  } pstate_t;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_AREF  = 3'd6,
    CMD_MODE  = 3'd7
  } cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic srExit;   // self refresh left at this edge: restart recovery count
  } ctrlStrobe_t;

endpackage

// File: rtl/cke_pstate_dp.sv
module cke_pstate_dp
  import cke_pstate_pkg::*;
#(
  parameter int EXIT_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cke,
  input  ctrlStrobe_t strobe,
  output logic        ckePrev,
  output logic        exitDone
);
  localparam int CNT_W = $clog2(EXIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EXIT_CYCLES);

  logic [CNT_W-1:0] exitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ckePrev <= 1'b1;
      exitCnt <= CNT_MAX;
    end else begin
      ckePrev <= cke;
      if (strobe.srExit)
        exitCnt <= '0;
      else if (exitCnt != CNT_MAX)
        exitCnt <= exitCnt + 1'b1;
    end
  end

  assign exitDone = (exitCnt == CNT_MAX);

endmodule

// File: rtl/cke_pstate_ctrl.sv
module cke_pstate_ctrl
  import cke_pstate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cke,
  input  logic        ckePrev,
  input  logic        bankActive,
  input  logic [2:0]  cmd,
  input  logic        exitDone,
  output pstate_t     stateQ,
  output logic        errQ,
  output ctrlStrobe_t strobe
);
  pstate_t nxtState;
  logic    isBad;
  logic    isQuiet;
  logic    lowPower;

  always_comb begin
    isQuiet  = (cmd == CMD_DESEL) || (cmd == CMD_NOP);
    lowPower = (stateQ == ST_PPD) || (stateQ == ST_APD) || (stateQ == ST_SREF);
    nxtState = stateQ;
    isBad    = 1'b0;
    strobe   = '0;
    if (lowPower) begin
      if (ckePrev) begin
        isBad = 1'b1;
      end else if (cke) begin
        if (isQuiet) begin
          case (stateQ)
            ST_PPD:  nxtState = ST_IDLE;
            ST_APD:  nxtState = ST_ACTIVE;
            default: begin
              nxtState      = ST_IDLE;
              strobe.srExit = 1'b1;
            end
          endcase
        end else begin
          isBad = 1'b1;
        end
      end
    end else begin
      if (!ckePrev)
        isBad = 1'b1;
      else if (!exitDone && !isQuiet)
        isBad = 1'b1;
      else if (cke)
        nxtState = bankActive ? ST_ACTIVE : ST_IDLE;
      else if (isQuiet)
        nxtState = bankActive ? ST_APD : ST_PPD;
      else if ((cmd == CMD_AREF) && !bankActive)
        nxtState = ST_SREF;
      else
        isBad = 1'b1;
    end
    if (isBad) begin
      nxtState      = stateQ;
      strobe.srExit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= nxtState;
      errQ   <= isBad;
    end
  end

endmodule

// File: rtl/cke_pstate_top.sv
module cke_pstate_top
  import cke_pstate_pkg::*;
#(
  parameter int EXIT_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       bankActive,
  input  logic [2:0] cmd,
  output logic [2:0] state,
  output logic       errPulse,
  output logic       readOk
);
  ctrlStrobe_t strobe;
  pstate_t     stateQ;
  logic        ckePrev;
  logic        exitDone;

  cke_pstate_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .ckePrev    (ckePrev),
    .bankActive (bankActive),
    .cmd        (cmd),
    .exitDone   (exitDone),
    .stateQ     (stateQ),
    .errQ       (errPulse),
    .strobe     (strobe)
  );

  cke_pstate_dp #(.EXIT_CYCLES(EXIT_CYCLES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .strobe   (strobe),
    .ckePrev  (ckePrev),
    .exitDone (exitDone)
  );

  assign state  = stateQ;
  assign readOk = exitDone && ((stateQ == ST_IDLE) || (stateQ == ST_ACTIVE));

endmodule

// File: rtl/cke_pstate_chk.sv
module cke_pstate_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       bankActive,
  input logic [2:0] cmd,
  input logic [2:0] state,
  input logic       errPulse,
  input logic       readOk
);
  logic ckeD;

  always_ff @(posedge clk) ckeD <= rst ? 1'b1 : cke;

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state == 3'd0 && readOk && !errPulse));

  // R2
  p_hold_lowpower_r2: assert property (@(posedge clk) disable iff (rst)
    (state >= 3'd2 && !ckeD && !cke) |=> (state == $past(state) && !errPulse));

  // R3
  p_sref_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd4 && !ckeD && cke && cmd <= 3'd1) |=> (state == 3'd0 && !readOk && !errPulse));

  // R6
  p_apd_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (state <= 3'd1 && ckeD && !cke && cmd <= 3'd1 && bankActive && readOk) |=> (state == 3'd3));

  // R8
  p_err_holds_r8: assert property (@(posedge clk) disable iff (rst)
    errPulse |-> (state == $past(state)));

  // R10
  p_read_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (state <= 3'd1 && ckeD && cmd == 3'd3 && !readOk) |=> errPulse);

endmodule

bind cke_pstate_top cke_pstate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cke        (cke),
  .bankActive (bankActive),
  .cmd        (cmd),
  .state      (state),
  .errPulse   (errPulse),
  .readOk     (readOk)
);

// File: tb/sim_cke_pstate_top.sv
`timescale 1ns/1ps
module sim_cke_pstate_top;
  localparam int EXITN = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       bankActive = 1'b0;
  logic [2:0] cmd = 3'd1;
  logic [2:0] state;
  logic       errPulse;
  logic       readOk;

  always #2 clk = ~clk;

  cke_pstate_top #(.EXIT_CYCLES(EXITN)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .bankActive(bankActive),
    .cmd(cmd), .state(state), .errPulse(errPulse), .readOk(readOk)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int mState, mPrev, mCnt;

  task automatic expect3(string tag, int es, int ee, int er);
    total++;
    if (state !== es[2:0] || errPulse !== ee[0] || readOk !== er[0]) begin
      bad++;
      $display("FAIL %s: state=%0d err=%0d rdok=%0d expected state=%0d err=%0d rdok=%0d",
               tag, state, errPulse, readOk, es, ee, er);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; cmd = 3'd1; bankActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mState = 0; mPrev = 1; mCnt = EXITN;
    expect3("R1 reset", 0, 0, 1);
  endtask

  // one clock of stimulus, expected values from the requirements
  task automatic step(string tag, bit ck, int c, bit ba);
    int nxt;
    bit quiet, badv, srx, rok;
    cke = ck; cmd = c[2:0]; bankActive = ba;
    quiet = (c <= 1);
    nxt = mState; badv = 0; srx = 0;
    if (mState >= 2) begin
      if (mPrev != 0) badv = 1;
      else if (ck) begin
        if (quiet) begin
          nxt = (mState == 3) ? 1 : 0;
          srx = (mState == 4);
        end else badv = 1;
      end
    end else begin
      if (mPrev == 0) badv = 1;
      else if (mCnt < EXITN && !quiet) badv = 1;
      else if (ck) nxt = ba ? 1 : 0;
      else if (quiet) nxt = ba ? 3 : 2;
      else if (c == 6 && !ba) nxt = 4;
      else badv = 1;
    end
    if (badv) begin nxt = mState; srx = 0; end
    mCnt = srx ? 0 : ((mCnt < EXITN) ? mCnt + 1 : mCnt);
    mPrev = ck;
    mState = nxt;
    rok = (mCnt == EXITN) && (mState <= 1);
    @(negedge clk);
    expect3(tag, mState, badv, rok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();

    // exhaustive sweep from every reachable state
    for (int s = 0; s < 5; s++) begin
      for (int ck = 0; ck < 2; ck++) begin
        for (int c = 0; c < 8; c++) begin
          for (int b = 0; b < 2; b++) begin
            doReset();
            case (s)
              1: step("R7 reach active", 1'b1, 1, 1'b1);
              2: step("R4 reach ppd", 1'b0, 1, 1'b0);
              3: step("R6 reach apd", 1'b0, 0, 1'b1);
              4: step("R5 reach sref", 1'b0, 6, 1'b0);
              default: ;
            endcase
            step("R2 R3 R7 R8 sweep", ck[0], c, b[0]);
          end
        end
      end
    end

    // recovery window edges
    doReset();
    step("R5 enter sref", 1'b0, 6, 1'b0);
    step("R2 stay sref", 1'b0, 3, 1'b0);
    step("R3 leave sref", 1'b1, 1, 1'b0);
    step("R9 activate in window", 1'b1, 2, 1'b0);
    for (int i = 0; i < EXITN - 2; i++) step("R9 wait", 1'b1, i % 2, 1'b0);
    step("R10 early read", 1'b1, 3, 1'b0);
    step("R10 read at limit", 1'b1, 3, 1'b0);
    step("R8 aref banks open", 1'b0, 6, 1'b1);

    // power-down inside the window
    doReset();
    step("R5 enter sref", 1'b0, 6, 1'b0);
    step("R3 leave sref", 1'b1, 0, 1'b0);
    step("R4 ppd in window", 1'b0, 1, 1'b0);
    step("R3 leave ppd", 1'b1, 1, 1'b1);
    step("R9 write in window", 1'b1, 4, 1'b1);

    // mixed traffic
    doReset();
    for (int i = 0; i < 6000; i++) begin
      int c;
      c = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 1);
      step("random mix", 1'($urandom_range(0, 1)), c, 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule